// File: doc/BRIEF.md
# Program Counter and Branch Decision Unit

This block owns the 16-bit program counter of a small accumulator machine and works out the counter's next value. A fetch strobe advances the counter by one, so by the time an instruction executes the counter already names the following word. An execute strobe, together with the 5-bit function code, the effective address and the zero, negative and overflow condition bits, selects a conditional jump, an unconditional jump, a subroutine call, a counted loop branch or a stop.

The machine has no return stack. The call instruction writes the return point into the index register through a write-enable and data pair. The loop instruction uses the same pair to write back the index value less one, and it branches while that new value is not zero.

The unit also guards the run. Two all-zero instruction words fetched in a row stop it with their own flag. An instruction budget, programmable at a port, stops it with an abort flag once the budget is spent. Every stop is sticky until reset.

Top module: `pc_branch_unit`

## Requirements
- R1: After reset the counter is RESET_PC (default 0), the halt, zero-pair and abort flags are low, and the index write-enable is low.
- R2: A fetch that is accepted adds one to the counter on the next clock edge, wrapping from 0xFFFF to 0.
- R3: On execute, code 5'o30 loads the effective address only when both zero and negative are clear. 5'o31 loads it when negative is set, 5'o32 when zero is set, and 5'o33 when overflow is set. When the condition fails the counter keeps its value.
- R4: On execute, code 5'o34 always loads the effective address into the counter.
- R5: On execute, code 5'o35 raises the index write-enable in that cycle with data equal to the current counter, and loads the effective address.
- R6: On execute, code 5'o36 raises the index write-enable with data equal to index minus one (modulo 2^16). It loads the effective address only if that value is nonzero.
- R7: On execute, code 5'o37 sets the halt flag. While any stop flag is set, fetch and execute have no effect: the counter holds and the index write-enable stays low.
- R8: An execute with any code below 5'o30 leaves the counter unchanged and never raises the index write-enable.
- R9: A fetch flagged as an all-zero word whose previous accepted fetch was also all-zero sets the zero-pair flag and does not advance the counter. A nonzero fetch in between clears the pairing.
- R10: A fetch made when the count of accepted fetches has already reached the limit input sets the abort flag and does not advance the counter.
- R11: A limit input of 0 selects the built-in budget DEF_LIMIT (default 100 fetches).
- R12: When fetch and execute are both asserted in one cycle, only the execute takes effect.
- R13: A single fetch that both completes a zero pair and exceeds the budget sets both the zero-pair and abort flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_i | input | 1 | Instruction fetch strobe |
| word_zero_i | input | 1 | Fetched word is all zero |
| exec_i | input | 1 | Execute strobe |
| func_i | input | 5 | Function code of the executing instruction |
| ea_i | input | 16 | Effective address |
| cc_zero_i | input | 1 | Zero condition bit |
| cc_neg_i | input | 1 | Negative condition bit |
| cc_ovf_i | input | 1 | Overflow condition bit |
| idx_i | input | 16 | Current index register value |
| limit_i | input | 16 | Fetch budget (0 selects DEF_LIMIT) |
| pc_o | output | 16 | Program counter |
| idx_we_o | output | 1 | Index register write-enable |
| idx_wdata_o | output | 16 | Index register write data |
| halt_o | output | 1 | Stop instruction executed |
| zero_err_o | output | 1 | Two zero words fetched in a row |
| abort_o | output | 1 | Fetch budget exceeded |

## Verification
The two guards that can fire on the same fetch are the zero-pair detector and the budget check. The bench sets the limit to 1, fetches one zero word, and then fetches a second zero word. That second fetch completes a pair and also exceeds the budget. The reference model expects both flags on the following edge, with the counter unchanged. A second collision is fetch and execute strobed together. It is provoked once with a jump and once with a logic code, and it is judged by whether the counter follows the execute alone.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  localparam int FN_W = 5;

  typedef enum logic [FN_W-1:0] {
    FN_IF_POS  = 5'o30,
    FN_IF_NEG  = 5'o31,
    FN_IF_ZERO = 5'o32,
    FN_IF_OVF  = 5'o33,
    FN_GOTO    = 5'o34,
    FN_CALL    = 5'o35,
    FN_LOOP    = 5'o36,
    FN_STOP    = 5'o37
  } br_fn_e;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
  } cc_t;

  // Branch condition for the codes that only move the counter.
  function automatic logic cond_met(input logic [FN_W-1:0] fn, input cc_t cc);
    case (fn)
      FN_IF_POS:  return !cc.z && !cc.n;
      FN_IF_NEG:  return cc.n;
      FN_IF_ZERO: return cc.z;
      FN_IF_OVF:  return cc.v;
      FN_GOTO:    return 1'b1;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pcb_decide.sv
module pcb_decide
  import pcb_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [FN_W-1:0] fn,
  input  cc_t             cc,
  input  logic [W-1:0]    pc,
  input  logic [W-1:0]    idx,
  output logic            jump,
  output logic            idx_we,
  output logic [W-1:0]    idx_wd,
  output logic            halt_req
);

  function automatic logic [W-1:0] idx_less_one(input logic [W-1:0] v);
    return v - W'(1);
  endfunction

  logic [W-1:0] idx_dec;
  assign idx_dec = idx_less_one(idx);

  always_comb begin
    jump     = 1'b0;
    idx_we   = 1'b0;
    idx_wd   = idx_dec;
    halt_req = 1'b0;
    case (fn)
      FN_CALL: begin
        idx_we = 1'b1;
        idx_wd = pc;
        jump   = 1'b1;
      end
      FN_LOOP: begin
        idx_we = 1'b1;
        jump   = |idx_dec;
      end
      FN_STOP: halt_req = 1'b1;
      default: jump = cond_met(fn, cc);
    endcase
  end

endmodule

// File: rtl/pcb_guard.sv
module pcb_guard #(
  parameter int CNT_W     = 16,
  parameter int DEF_LIMIT = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_go,
  input  logic             word_zero,
  input  logic [CNT_W-1:0] limit,
  output logic             trip_zero,
  output logic             trip_limit
);

  localparam logic [CNT_W-1:0] DEF_CNT = CNT_W'(DEF_LIMIT);

  logic             prev_zero;
  logic [CNT_W-1:0] fetch_cnt;
  logic [CNT_W-1:0] eff_limit;
  logic             accept;

  assign eff_limit  = (limit == '0) ? DEF_CNT : limit;
  assign trip_zero  = fetch_go && word_zero && prev_zero;
  assign trip_limit = fetch_go && (fetch_cnt >= eff_limit);
  assign accept     = fetch_go && !trip_zero && !trip_limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_zero <= 1'b0;
      fetch_cnt <= '0;
    end else if (accept) begin
      prev_zero <= word_zero;
      fetch_cnt <= fetch_cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
  import pcb_pkg::*;
#(
  parameter int          PC_W      = 16,
  parameter int          CNT_W     = 16,
  parameter int          DEF_LIMIT = 100,
  parameter logic [15:0] RESET_PC  = 16'h0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_i,
  input  logic             word_zero_i,
  input  logic             exec_i,
  input  logic [FN_W-1:0]  func_i,
  input  logic [PC_W-1:0]  ea_i,
  input  logic             cc_zero_i,
  input  logic             cc_neg_i,
  input  logic             cc_ovf_i,
  input  logic [PC_W-1:0]  idx_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [PC_W-1:0]  pc_o,
  output logic             idx_we_o,
  output logic [PC_W-1:0]  idx_wdata_o,
  output logic             halt_o,
  output logic             zero_err_o,
  output logic             abort_o
);

  function automatic logic [PC_W-1:0] pc_step(input logic [PC_W-1:0] p);
    return p + PC_W'(1);
  endfunction

  // Named internal events, visible to the bound checker.
  logic stopped;
  logic exec_go;
  logic fetch_go;
  logic take_jump;
  logic halt_req;
  logic dec_we;
  logic trip_zero;
  logic trip_limit;
  logic fetch_ok;
  cc_t  cc;

  logic [PC_W-1:0] pc_q;
  logic            halt_q, zerr_q, abort_q;

  assign cc       = '{z: cc_zero_i, n: cc_neg_i, v: cc_ovf_i};
  assign stopped  = halt_q || zerr_q || abort_q;
  assign exec_go  = exec_i && !stopped;
  assign fetch_go = fetch_i && !exec_i && !stopped;
  assign fetch_ok = fetch_go && !trip_zero && !trip_limit;

  pcb_decide #(.W(PC_W)) u_decide (
    .fn       (func_i),
    .cc       (cc),
    .pc       (pc_q),
    .idx      (idx_i),
    .jump     (take_jump),
    .idx_we   (dec_we),
    .idx_wd   (idx_wdata_o),
    .halt_req (halt_req)
  );

  pcb_guard #(.CNT_W(CNT_W), .DEF_LIMIT(DEF_LIMIT)) u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_go   (fetch_go),
    .word_zero  (word_zero_i),
    .limit      (limit_i),
    .trip_zero  (trip_zero),
    .trip_limit (trip_limit)
  );

  assign idx_we_o = exec_go && dec_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= PC_W'(RESET_PC);
    end else if (exec_go && take_jump) begin
      pc_q <= ea_i;
    end else if (fetch_ok) begin
      pc_q <= pc_step(pc_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_q  <= 1'b0;
      zerr_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      if (exec_go && halt_req) halt_q  <= 1'b1;
      if (trip_zero)           zerr_q  <= 1'b1;
      if (trip_limit)          abort_q <= 1'b1;
    end
  end

  assign pc_o       = pc_q;
  assign halt_o     = halt_q;
  assign zero_err_o = zerr_q;
  assign abort_o    = abort_q;

endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         fetch_i,
  input logic         word_zero_i,
  input logic [4:0]   func_i,
  input logic [W-1:0] ea_i,
  input logic [W-1:0] idx_i,
  input logic [W-1:0] pc_o,
  input logic         idx_we_o,
  input logic [W-1:0] idx_wdata_o,
  input logic         zero_err_o,
  input logic         abort_o,
  input logic         stopped,
  input logic         exec_go,
  input logic         fetch_go,
  input logic         trip_zero,
  input logic         trip_limit,
  input logic         take_jump
);

  a_r2_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go && !trip_zero && !trip_limit |=> pc_o == $past(pc_o) + W'(1));

  a_r4_goto: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go && func_i == 5'o34 |=> pc_o == $past(ea_i));

  a_r5_link: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go && func_i == 5'o35 |-> idx_we_o && idx_wdata_o == pc_o);

  a_r6_loop_data: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go && func_i == 5'o36 |-> idx_we_o && idx_wdata_o == idx_i - W'(1));

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> stopped && $stable(pc_o) && !idx_we_o);

  a_r8_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go && func_i < 5'o30 |=> $stable(pc_o));

  a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go && func_i < 5'o30 |-> !idx_we_o);

  a_r9_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
    trip_zero |-> word_zero_i);

  a_r9_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_err_o) |-> $past(fetch_i) && $past(word_zero_i));

  a_r10_abort_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_o) |-> $past(fetch_i) && $stable(pc_o));

  a_r12_exec_only: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go && fetch_i && !take_jump |=> $stable(pc_o));

endmodule

bind pc_branch_unit pcb_checker #(.W(PC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_i     (fetch_i),
  .word_zero_i (word_zero_i),
  .func_i      (func_i),
  .ea_i        (ea_i),
  .idx_i       (idx_i),
  .pc_o        (pc_o),
  .idx_we_o    (idx_we_o),
  .idx_wdata_o (idx_wdata_o),
  .zero_err_o  (zero_err_o),
  .abort_o     (abort_o),
  .stopped     (stopped),
  .exec_go     (exec_go),
  .fetch_go    (fetch_go),
  .trip_zero   (trip_zero),
  .trip_limit  (trip_limit),
  .take_jump   (take_jump)
);

// File: tb/tb_pc_branch_unit.sv
`timescale 1ns/1ps
module tb_pc_branch_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_i, word_zero_i, exec_i;
  logic [4:0]  func_i;
  logic [15:0] ea_i, idx_i, limit_i;
  logic        cc_zero_i, cc_neg_i, cc_ovf_i;
  logic [15:0] pc_o, idx_wdata_o;
  logic        idx_we_o, halt_o, zero_err_o, abort_o;

  always #2.5 clk = ~clk;

  pc_branch_unit dut (
    .clk(clk), .rst_n(rst_n), .fetch_i(fetch_i), .word_zero_i(word_zero_i),
    .exec_i(exec_i), .func_i(func_i), .ea_i(ea_i), .cc_zero_i(cc_zero_i),
    .cc_neg_i(cc_neg_i), .cc_ovf_i(cc_ovf_i), .idx_i(idx_i), .limit_i(limit_i),
    .pc_o(pc_o), .idx_we_o(idx_we_o), .idx_wdata_o(idx_wdata_o),
    .halt_o(halt_o), .zero_err_o(zero_err_o), .abort_o(abort_o)
  );

  int errors = 0;
  int checks = 0;

  // Behavioural reference state
  int unsigned m_pc;
  bit          m_halt, m_zerr, m_abort, m_prevz;
  int          m_cnt;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive_idle();
    fetch_i = 0; word_zero_i = 0; exec_i = 0; func_i = 0; ea_i = 0;
    cc_zero_i = 0; cc_neg_i = 0; cc_ovf_i = 0; idx_i = 0;
  endtask

  task automatic do_reset(logic [15:0] lim);
    @(negedge clk);
    rst_n = 0; drive_idle(); limit_i = lim;
    repeat (3) @(posedge clk);
    m_pc = 0; m_halt = 0; m_zerr = 0; m_abort = 0; m_prevz = 0; m_cnt = 0;
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", "pc", pc_o, 0);
    chk("R1", "flags", {halt_o, zero_err_o, abort_o}, 0);
    chk("R1", "idx_we", idx_we_o, 0);
  endtask

  task automatic step(bit fe, bit zw, bit ex, logic [4:0] fn, logic [15:0] ea,
                      bit z, bit n, bit v, logic [15:0] idx, string req);
    bit stp, ewe, over, pair;
    int unsigned ewd;
    int lim_eff;
    @(negedge clk);
    fetch_i = fe; word_zero_i = zw; exec_i = ex; func_i = fn; ea_i = ea;
    cc_zero_i = z; cc_neg_i = n; cc_ovf_i = v; idx_i = idx;
    stp = m_halt || m_zerr || m_abort;
    ewe = 0; ewd = 0;
    if (!stp && ex) begin
      if (fn == 5'o35) begin ewe = 1; ewd = m_pc; end
      else if (fn == 5'o36) begin ewe = 1; ewd = (int'(idx) + 65535) % 65536; end
    end
    #1;
    chk(req, "idx_we", idx_we_o, ewe);
    if (ewe) chk(req, "idx_wdata", idx_wdata_o, ewd);
    if (!stp) begin
      if (ex) begin
        case (fn)
          5'o30: if (!z && !n) m_pc = ea;
          5'o31: if (n) m_pc = ea;
          5'o32: if (z) m_pc = ea;
          5'o33: if (v) m_pc = ea;
          5'o34, 5'o35: m_pc = ea;
          5'o36: if (ewd != 0) m_pc = ea;
          5'o37: m_halt = 1;
          default: ;
        endcase
      end else if (fe) begin
        lim_eff = (limit_i == 0) ? 100 : int'(limit_i);
        over = m_cnt >= lim_eff;
        pair = zw && m_prevz;
        if (over) m_abort = 1;
        if (pair) m_zerr = 1;
        if (!over && !pair) begin
          m_pc = (m_pc + 1) % 65536;
          m_cnt++;
          m_prevz = zw;
        end
      end
    end
    @(posedge clk);
    #1;
    chk(req, "pc", pc_o, m_pc);
    chk(req, "halt", halt_o, m_halt);
    chk(req, "zero_err", zero_err_o, m_zerr);
    chk(req, "abort", abort_o, m_abort);
  endtask

  task automatic fetch(bit zw, string req);
    step(1, zw, 0, 5'o0, 16'h0, 0, 0, 0, 16'h0, req);
  endtask

  task automatic exec_op(logic [4:0] fn, logic [15:0] ea, bit z, bit n, bit v,
                         logic [15:0] idx, string req);
    step(0, 0, 1, fn, ea, z, n, v, idx, req);
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; drive_idle(); limit_i = 0;
    do_reset(16'd0);                          // R1

    fetch(0, "R2"); fetch(0, "R2"); fetch(0, "R2");
    exec_op(5'o34, 16'h0100, 0, 0, 0, 0, "R4");
    exec_op(5'o34, 16'h1234, 1, 1, 1, 0, "R4");
    // R3 conditional jumps, taken and not taken
    exec_op(5'o30, 16'h0200, 0, 0, 0, 0, "R3");
    exec_op(5'o30, 16'h0300, 1, 0, 0, 0, "R3");
    exec_op(5'o30, 16'h0300, 0, 1, 0, 0, "R3");
    exec_op(5'o31, 16'h0310, 0, 1, 0, 0, "R3");
    exec_op(5'o31, 16'h0320, 1, 0, 1, 0, "R3");
    exec_op(5'o32, 16'h0330, 1, 0, 0, 0, "R3");
    exec_op(5'o32, 16'h0340, 0, 1, 1, 0, "R3");
    exec_op(5'o33, 16'h0350, 0, 0, 1, 0, "R3");
    exec_op(5'o33, 16'h0360, 1, 1, 0, 0, "R3");
    fetch(0, "R2");
    // R5 call links the already-advanced counter
    exec_op(5'o35, 16'h0400, 0, 0, 0, 16'h7777, "R5");
    fetch(0, "R2");
    // R6 loop branch
    exec_op(5'o36, 16'h0500, 0, 0, 0, 16'd5, "R6");
    exec_op(5'o36, 16'h0600, 0, 0, 0, 16'd1, "R6");
    exec_op(5'o36, 16'h0700, 0, 0, 0, 16'd0, "R6");
    // R8 other codes
    exec_op(5'o04, 16'h0AAA, 1, 1, 1, 16'd3, "R8");
    exec_op(5'o27, 16'h0BBB, 0, 0, 0, 16'd3, "R8");
    exec_op(5'o00, 16'h0CCC, 0, 0, 0, 16'd3, "R8");
    // R12 fetch and execute together
    step(1, 0, 1, 5'o34, 16'h0900, 0, 0, 0, 0, "R12");
    step(1, 0, 1, 5'o12, 16'h0A00, 0, 0, 0, 0, "R12");
    // R2 wrap
    exec_op(5'o34, 16'hFFFF, 0, 0, 0, 0, "R4");
    fetch(0, "R2");
    // R9 zero pair
    fetch(1, "R9"); fetch(0, "R9"); fetch(1, "R9"); fetch(1, "R9");
    fetch(0, "R9");
    exec_op(5'o34, 16'h0123, 0, 0, 0, 0, "R7");

    // R7 halt and freeze
    do_reset(16'd0);
    fetch(0, "R2");
    exec_op(5'o37, 16'h0, 0, 0, 0, 0, "R7");
    exec_op(5'o34, 16'h0444, 0, 0, 0, 0, "R7");
    exec_op(5'o35, 16'h0444, 0, 0, 0, 16'd9, "R7");
    fetch(0, "R7");

    // R10 explicit budget
    do_reset(16'd3);
    fetch(0, "R10"); fetch(0, "R10"); fetch(0, "R10");
    exec_op(5'o34, 16'h0050, 0, 0, 0, 0, "R10");
    fetch(0, "R10");
    fetch(0, "R10");

    // R11 zero limit selects the built-in budget of 100
    do_reset(16'd0);
    for (int i = 0; i < 100; i++) fetch(0, "R11");
    fetch(0, "R11");

    // R13 both guards on one fetch
    do_reset(16'd1);
    fetch(1, "R13");
    fetch(1, "R13");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule